// File: doc/BRIEF.md
# Multi-Channel Transceiver Reset Sequencer

This block orders the reset release of a group of serial transceiver channels. It runs on a free-running controller clock. For each channel it drives an analog RX reset, a digital RX reset, an RX ready flag and a digital TX reset. It also drives one powerdown line for each transmit PLL. Each channel's receive side leaves reset only after three things hold together: its calibration has finished, its analog reset is gone, and its clock-data recovery has locked to incoming data (or the channel is in manual mode). Once they hold, a fixed countdown runs, and only when it ends is the digital reset released. RX ready follows a short, fixed delay later.

The transmit side of each channel waits on one PLL lock flag, chosen from several by a per-channel select field packed into one bus. That flag must stay high for a full countdown before the TX digital reset drops. A select value that names no PLL is treated as unlocked. With the `SHARED_TX` parameter set, one select field and one TX sequence serve every channel. Calibration-busy, data-lock and PLL-lock inputs are asynchronous and are retimed inside the block.

Top module: `xcvr_rst_seq`

## Requirements
- R1: A channel's analog RX reset is high on every edge where the global reset is high. It is also high from the third edge after its calibration-busy input is first sampled high, and falls on the third edge after that input is first sampled low.
- R2: A channel's digital RX reset stays high while any of these holds: global reset, its analog RX reset, its synchronized calibration-busy flag, or its synchronized data-lock flag low with manual mode off.
- R3: Let e0 be the first edge at which none of the R2 conditions holds. The digital RX reset falls on edge e0 + `RX_CNT`. With `RX_CNT` = 20, a data-lock rise sampled at edge A1 (all else clear) gives a release at edge A1 + 22.
- R4: RX ready is low on every cycle the digital RX reset is high, and it drops on the same edge at which that reset reasserts. It rises `RDY_DLY` edges after the digital RX reset falls.
- R5: Every per-channel output bit depends only on that channel's inputs and its select field. Releasing one channel leaves the others in reset.
- R6: If a holding condition returns during the countdown, the countdown reloads to its full length. Release is then timed from the new e0.
- R7: With manual mode high, the data-lock flag is ignored. Manual mode is a static input that is not synchronized, so e0 is the first edge after manual mode is set.
- R8: Channel i's TX select field sits at bits [i*`SEL_W` +: `SEL_W`] of the select bus, and value k chooses PLL lock flag k. The TX digital reset falls `TX_CNT` edges after the first edge at which the synchronized chosen flag is high. It rises again on the edge at which a synchronized low is first seen.
- R9: Calibration-busy, data-lock and PLL-lock inputs pass through two flops, so a change sampled at edge A1 reaches the sequencing logic at edge A3.
- R10: A select value of `NUM_PLL` or more counts as unlocked, so that channel's TX digital reset stays high.
- R11: Every PLL powerdown bit is high after any edge at which the global reset is high, and low after any edge at which it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Global reset, synchronous, active high |
| cal_busy | input | NUM_CH | Per-channel calibration in progress (async) |
| cdr_lock | input | NUM_CH | Per-channel recovery locked to data (async) |
| rx_manual | input | NUM_CH | Per-channel: ignore data-lock for release |
| pll_locked | input | NUM_PLL | Lock flag of each transmit PLL (async) |
| pll_sel | input | NUM_CH*SEL_W (SEL_W if shared) | Packed per-channel PLL select fields |
| rx_ana_rst | output | NUM_CH | Analog RX reset per channel |
| rx_dig_rst | output | NUM_CH | Digital RX reset per channel |
| rx_rdy | output | NUM_CH | RX sequence complete per channel |
| tx_dig_rst | output | NUM_CH | Digital TX reset per channel |
| pll_pwrdn | output | NUM_PLL | Powerdown per transmit PLL |

## Verification
The bench times each release to the exact edge. If a design forgot the synchronizer stages or the reload of the countdown, it would release one or more cycles early, and the check one edge before release would fail. In the abort case the data lock drops halfway through a countdown. A timer that paused instead of reloading would release about ten cycles early. The bench also checks that a calibration pulse keeps the digital reset held one extra edge while the analog reset clears, and that manual mode bypasses a missing data lock. On the TX side it tests an out-of-range select, a select pointing at a low PLL, a select change to a locked PLL, and loss of lock; a design that indexed the wrong field or wrapped the select value would release the wrong channel.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_DONE  = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic cal;
        logic lock;
        logic manual;
    } rx_stat_t;

    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import xcvr_rst_pkg::*;

    logic [W-1:0] stg [SYNC_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_DEPTH; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < SYNC_DEPTH; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[SYNC_DEPTH-1];
endmodule

// File: rtl/xcvr_timer.sv
module xcvr_timer #(
    parameter int CNT = 16
) (
    input  logic clk,
    input  logic hold,
    output logic rst_o
);
    import xcvr_rst_pkg::*;

    localparam int CW = cnt_w(CNT);
    localparam logic [CW-1:0] LOAD = CW'(CNT);

    tmr_state_e      st;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (hold) begin
            st  <= TMR_HOLD;
            cnt <= LOAD;
        end else if (st != TMR_DONE) begin
            if (cnt == '0) begin
                st <= TMR_DONE;
            end else begin
                st  <= TMR_COUNT;
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign rst_o = (st != TMR_DONE);
endmodule

// File: rtl/xcvr_rx_chan.sv
module xcvr_rx_chan #(
    parameter int RX_CNT  = 20,
    parameter int RDY_DLY = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  xcvr_rst_pkg::rx_stat_t  stat,
    output logic                    ana_rst,
    output logic                    dig_rst,
    output logic                    rdy
);
    import xcvr_rst_pkg::*;

    localparam int RW = cnt_w(RDY_DLY);
    localparam logic [RW-1:0] RDY_LAST = RW'(RDY_DLY - 1);

    logic          hold;
    logic [RW-1:0] rcnt;

    always_ff @(posedge clk) begin
        ana_rst <= rst | stat.cal;
    end

    assign hold = rst | ana_rst | stat.cal | (~stat.lock & ~stat.manual);

    xcvr_timer #(.CNT(RX_CNT)) u_tmr (
        .clk  (clk),
        .hold (hold),
        .rst_o(dig_rst)
    );

    always_ff @(posedge clk) begin
        if (hold || dig_rst) begin
            rcnt <= '0;
            rdy  <= 1'b0;
        end else if (!rdy) begin
            if (rcnt == RDY_LAST) rdy  <= 1'b1;
            else                  rcnt <= rcnt + 1'b1;
        end
    end
endmodule

// File: rtl/xcvr_tx_chan.sv
module xcvr_tx_chan #(
    parameter int NUM_PLL = 3,
    parameter int SEL_W   = 2,
    parameter int TX_CNT  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PLL-1:0] pll_s,
    input  logic [SEL_W-1:0]   sel,
    output logic               dig_rst
);
    logic lock;
    logic hold;

    always_comb begin
        lock = 1'b0;
        for (int p = 0; p < NUM_PLL; p++) begin
            if (sel == SEL_W'(p)) lock = pll_s[p];
        end
    end

    assign hold = rst | ~lock;

    xcvr_timer #(.CNT(TX_CNT)) u_tmr (
        .clk  (clk),
        .hold (hold),
        .rst_o(dig_rst)
    );
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
    parameter int NUM_CH    = 3,
    parameter int NUM_PLL   = 3,
    parameter int SEL_W     = 2,
    parameter int RX_CNT    = 20,
    parameter int TX_CNT    = 12,
    parameter int RDY_DLY   = 3,
    parameter bit SHARED_TX = 1'b0
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [NUM_CH-1:0]                              cal_busy,
    input  logic [NUM_CH-1:0]                              cdr_lock,
    input  logic [NUM_CH-1:0]                              rx_manual,
    input  logic [NUM_PLL-1:0]                             pll_locked,
    input  logic [(SHARED_TX ? SEL_W : NUM_CH*SEL_W)-1:0]  pll_sel,
    output logic [NUM_CH-1:0]                              rx_ana_rst,
    output logic [NUM_CH-1:0]                              rx_dig_rst,
    output logic [NUM_CH-1:0]                              rx_rdy,
    output logic [NUM_CH-1:0]                              tx_dig_rst,
    output logic [NUM_PLL-1:0]                             pll_pwrdn
);
    import xcvr_rst_pkg::*;

    logic [NUM_CH-1:0]  cal_s;
    logic [NUM_CH-1:0]  lock_s;
    logic [NUM_PLL-1:0] pll_s;

    xcvr_sync #(.W(NUM_CH))  u_sync_cal  (.clk(clk), .rst(rst), .d(cal_busy),   .q(cal_s));
    xcvr_sync #(.W(NUM_CH))  u_sync_lock (.clk(clk), .rst(rst), .d(cdr_lock),   .q(lock_s));
    xcvr_sync #(.W(NUM_PLL)) u_sync_pll  (.clk(clk), .rst(rst), .d(pll_locked), .q(pll_s));

    always_ff @(posedge clk) begin
        pll_pwrdn <= {NUM_PLL{rst}};
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_rx
        rx_stat_t st;
        assign st = '{cal: cal_s[i], lock: lock_s[i], manual: rx_manual[i]};

        xcvr_rx_chan #(.RX_CNT(RX_CNT), .RDY_DLY(RDY_DLY)) u_rx (
            .clk    (clk),
            .rst    (rst),
            .stat   (st),
            .ana_rst(rx_ana_rst[i]),
            .dig_rst(rx_dig_rst[i]),
            .rdy    (rx_rdy[i])
        );
    end

    if (SHARED_TX) begin : g_tx_shared
        logic tx_one;
        xcvr_tx_chan #(.NUM_PLL(NUM_PLL), .SEL_W(SEL_W), .TX_CNT(TX_CNT)) u_tx (
            .clk    (clk),
            .rst    (rst),
            .pll_s  (pll_s),
            .sel    (pll_sel[SEL_W-1:0]),
            .dig_rst(tx_one)
        );
        assign tx_dig_rst = {NUM_CH{tx_one}};
    end else begin : g_tx_per
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            xcvr_tx_chan #(.NUM_PLL(NUM_PLL), .SEL_W(SEL_W), .TX_CNT(TX_CNT)) u_tx (
                .clk    (clk),
                .rst    (rst),
                .pll_s  (pll_s),
                .sel    (pll_sel[i*SEL_W +: SEL_W]),
                .dig_rst(tx_dig_rst[i])
            );
        end
    end
endmodule

// File: rtl/xcvr_rst_chk.sv
module xcvr_rst_chk #(
    parameter int NUM_CH    = 3,
    parameter int NUM_PLL   = 3,
    parameter int SEL_W     = 2,
    parameter bit SHARED_TX = 1'b0
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [(SHARED_TX ? SEL_W : NUM_CH*SEL_W)-1:0]  pll_sel,
    input  logic [NUM_CH-1:0]                              rx_ana_rst,
    input  logic [NUM_CH-1:0]                              rx_dig_rst,
    input  logic [NUM_CH-1:0]                              rx_rdy,
    input  logic [NUM_CH-1:0]                              tx_dig_rst,
    input  logic [NUM_PLL-1:0]                             pll_pwrdn
);
    localparam int SW1 = SEL_W + 1;
    localparam logic [SW1-1:0] NPLL_V = SW1'(NUM_PLL);

    assert_ana_implies_dig_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_ana_rst & ~rx_dig_rst) == '0);

    assert_rdy_low_in_rst_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_dig_rst & rx_rdy) == '0);

    assert_pwrdn_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pll_pwrdn == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int FI = SHARED_TX ? 0 : i;

        assert_rx_release_clean_R3: assert property (@(posedge clk) disable iff (rst)
            $fell(rx_dig_rst[i]) |-> !$past(rx_ana_rst[i]));

        assert_tx_sel_in_range_R10: assert property (@(posedge clk) disable iff (rst)
            $fell(tx_dig_rst[i]) |-> ({1'b0, $past(pll_sel[FI*SEL_W +: SEL_W])} < NPLL_V));
    end
endmodule

bind xcvr_rst_seq xcvr_rst_chk #(
    .NUM_CH(NUM_CH), .NUM_PLL(NUM_PLL), .SEL_W(SEL_W), .SHARED_TX(SHARED_TX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pll_sel   (pll_sel),
    .rx_ana_rst(rx_ana_rst),
    .rx_dig_rst(rx_dig_rst),
    .rx_rdy    (rx_rdy),
    .tx_dig_rst(tx_dig_rst),
    .pll_pwrdn (pll_pwrdn)
);

// File: tb/tb_xcvr_rst_seq.sv
`timescale 1ns/1ps
module tb_xcvr_rst_seq;
    localparam int NUM_CH  = 3;
    localparam int NUM_PLL = 3;
    localparam int SEL_W   = 2;
    localparam int RX_CNT  = 20;
    localparam int TX_CNT  = 12;
    localparam int RDY_DLY = 3;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [NUM_CH-1:0]         cal_busy = '0;
    logic [NUM_CH-1:0]         cdr_lock = '0;
    logic [NUM_CH-1:0]         rx_manual = '0;
    logic [NUM_PLL-1:0]        pll_locked = '0;
    logic [NUM_CH*SEL_W-1:0]   pll_sel = '0;
    logic [NUM_CH-1:0]         rx_ana_rst, rx_dig_rst, rx_rdy, tx_dig_rst;
    logic [NUM_PLL-1:0]        pll_pwrdn;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    xcvr_rst_seq #(
        .NUM_CH(NUM_CH), .NUM_PLL(NUM_PLL), .SEL_W(SEL_W),
        .RX_CNT(RX_CNT), .TX_CNT(TX_CNT), .RDY_DLY(RDY_DLY), .SHARED_TX(1'b0)
    ) dut (
        .clk(clk), .rst(rst), .cal_busy(cal_busy), .cdr_lock(cdr_lock),
        .rx_manual(rx_manual), .pll_locked(pll_locked), .pll_sel(pll_sel),
        .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst), .rx_rdy(rx_rdy),
        .tx_dig_rst(tx_dig_rst), .pll_pwrdn(pll_pwrdn)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        edges(2);
        check("R1 ana in reset", 32'(rx_ana_rst), 32'h7);
        check("R2 dig in reset", 32'(rx_dig_rst), 32'h7);
        check("R4 rdy in reset", 32'(rx_rdy), 32'h0);
        check("R8 tx in reset", 32'(tx_dig_rst), 32'h7);
        check("R11 pwrdn in reset", 32'(pll_pwrdn), 32'h7);
        rst = 1'b0;
        edges(1);
        check("R1 ana clears", 32'(rx_ana_rst), 32'h0);
        check("R11 pwrdn clears", 32'(pll_pwrdn), 32'h0);
        edges(30);
        check("R2 no data lock holds dig", 32'(rx_dig_rst), 32'h7);
        check("R10 sel 0 pll low holds tx", 32'(tx_dig_rst), 32'h7);
    endtask

    task automatic t_rx_release();
        cdr_lock[0] = 1'b1;
        edges(2 + RX_CNT);
        check("R3 dig0 before release", 32'(rx_dig_rst[0]), 32'h1);
        check("R9 sync delay rdy0 low", 32'(rx_rdy[0]), 32'h0);
        edges(1);
        check("R3 dig0 released", 32'(rx_dig_rst[0]), 32'h0);
        check("R5 others held", 32'(rx_dig_rst[2:1]), 32'h3);
        edges(RDY_DLY - 1);
        check("R4 rdy0 before delay", 32'(rx_rdy[0]), 32'h0);
        edges(1);
        check("R4 rdy0 rises", 32'(rx_rdy[0]), 32'h1);
        check("R5 others not ready", 32'(rx_rdy[2:1]), 32'h0);
    endtask

    task automatic t_cal_pulse();
        cal_busy[0] = 1'b1;
        edges(2);
        check("R9 ana0 not yet", 32'(rx_ana_rst[0]), 32'h0);
        edges(1);
        check("R1 ana0 on cal", 32'(rx_ana_rst[0]), 32'h1);
        check("R2 dig0 on cal", 32'(rx_dig_rst[0]), 32'h1);
        check("R4 rdy0 drops", 32'(rx_rdy[0]), 32'h0);
        edges(5);
        cal_busy[0] = 1'b0;
        edges(3);
        check("R1 ana0 clears", 32'(rx_ana_rst[0]), 32'h0);
        edges(RX_CNT);
        check("R2 ana hold adds an edge", 32'(rx_dig_rst[0]), 32'h1);
        edges(1);
        check("R3 dig0 re-released", 32'(rx_dig_rst[0]), 32'h0);
    endtask

    task automatic t_abort();
        cdr_lock[1] = 1'b1;
        edges(RX_CNT / 2);
        cdr_lock[1] = 1'b0;
        edges(3);
        check("R6 dig1 held during drop", 32'(rx_dig_rst[1]), 32'h1);
        cdr_lock[1] = 1'b1;
        edges(2 + RX_CNT);
        check("R6 countdown reloaded", 32'(rx_dig_rst[1]), 32'h1);
        edges(1);
        check("R6 dig1 released", 32'(rx_dig_rst[1]), 32'h0);
    endtask

    task automatic t_manual();
        rx_manual[2] = 1'b1;
        edges(RX_CNT);
        check("R7 dig2 before release", 32'(rx_dig_rst[2]), 32'h1);
        edges(1);
        check("R7 manual ignores lock", 32'(rx_dig_rst[2]), 32'h0);
    endtask

    task automatic t_tx();
        // ch0 -> pll2, ch1 -> 3 (no such pll), ch2 -> pll0
        pll_sel = {2'd0, 2'd3, 2'd2};
        pll_locked = 3'b110;
        edges(2 + TX_CNT);
        check("R8 tx0 before release", 32'(tx_dig_rst[0]), 32'h1);
        edges(1);
        check("R8 tx0 released", 32'(tx_dig_rst[0]), 32'h0);
        check("R8 tx2 pll0 low", 32'(tx_dig_rst[2]), 32'h1);
        edges(20);
        check("R10 out of range sel held", 32'(tx_dig_rst[1]), 32'h1);
        pll_sel[5:4] = 2'd1;
        edges(TX_CNT);
        check("R8 tx2 before release", 32'(tx_dig_rst[2]), 32'h1);
        edges(1);
        check("R8 tx2 on pll1", 32'(tx_dig_rst[2]), 32'h0);
        pll_locked[2] = 1'b0;
        edges(2);
        check("R9 tx0 loss not yet seen", 32'(tx_dig_rst[0]), 32'h0);
        edges(1);
        check("R8 tx0 reasserts on loss", 32'(tx_dig_rst[0]), 32'h1);
        check("R5 tx2 unaffected", 32'(tx_dig_rst[2]), 32'h0);
    endtask

    task automatic t_rereset();
        rst = 1'b1;
        edges(1);
        check("R11 pwrdn on reset", 32'(pll_pwrdn), 32'h7);
        check("R1 ana on reset", 32'(rx_ana_rst), 32'h7);
        check("R4 rdy off on reset", 32'(rx_rdy), 32'h0);
        check("R2 dig on reset", 32'(rx_dig_rst), 32'h7);
        rst = 1'b0;
        edges(1);
        check("R11 pwrdn off", 32'(pll_pwrdn), 32'h0);
    endtask

    initial begin
        t_reset();
        t_rx_release();
        t_cal_pulse();
        t_abort();
        t_manual();
        t_tx();
        t_rereset();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule